// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Claim and Completion

This block collects level interrupt requests from a set of sources and presents one interrupt line to a single processor context. Each request is latched into a per-source pending flag. Software programs a small priority value for each source, an enable flag for each source and a global threshold. The interrupt line is high whenever some source is pending, enabled and above the threshold.

Software services an interrupt in two bus steps. A read of the claim word returns the ID of the best waiting source. That read also clears the source's pending flag and marks the source as in service. While a source is in service, new requests on it are blocked. Software later writes the same ID back to the claim word. This completion releases the source, so that a request that is still held can be latched again. ID 0 is reserved and means that nothing is waiting.

The bus addresses 32-bit words. Read data is registered and appears on `bus_rdata_o` one cycle after the read strobe. Arbitration is evaluated from registered state, so any claim, completion or register write shows up on `irq_o` in the cycle that follows it.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every pending, in-service, enable and priority flag and the threshold are zero. `irq_o` is low, `active_id_o` is 0, and a claim read returns 0.
- R2: The priority of source k (k ≥ 1) sits at word address k-1. A write keeps only bits [2:0] of the data. A read returns the stored value zero-extended. Word NSRC-1 is reserved, is ignored on write and reads 0.
- R3: The enable flag of source s sits at word 0x50 + s/32, bit s%32. Bit 0 of word 0x50 (source 0) and bits above the last source always read 0.
- R4: A source whose request input is high for at least one cycle, and which is not in service, has its pending flag set. The flag stays set after the request drops, until that source is claimed. The flag is readable at word 0x40 + s/32, bit s%32. Writes to these words are ignored.
- R5: While a source is in service, its request input cannot set its pending flag.
- R6: A source is eligible only if it is pending, enabled and has a priority strictly greater than the threshold (word 0x60, bits [2:0]). `irq_o` is high exactly when some source is eligible.
- R7: Among the eligible sources, the one with the highest priority wins. On equal priority the lowest ID wins.
- R8: A read of the claim word (0x61) returns the winning ID one cycle later. The same read clears the winner's pending flag, marks it in service and sets `active_id_o` to that ID. If nothing is eligible, the read returns 0 and changes no state.
- R9: A write of ID v to the claim word, with 1 ≤ v < NSRC, ends service of source v. If v equals `active_id_o`, `active_id_o` returns to 0; otherwise `active_id_o` is unchanged. A value of 0, or a value of NSRC or more, has no effect.
- R10: After a priority, enable or threshold write, or after a claim or a completion, `irq_o` reflects the new state in the next cycle.
- R11: When a claim read and a request on the winning source fall in the same cycle, the clear wins. The pending flag stays clear while the source remains in service.
- R12: When a completion is written while the source's request is still high, the pending flag becomes set one cycle after the completion takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Level request per source; bit 0 is unused |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the processor context |
| active_id_o | output | $clog2(NSRC) | ID most recently claimed and not yet completed, or 0 |

## Verification
Two events can coincide on one source: a claim read that takes a source, and a fresh level request on that same source. The bench holds a source's request high through the claim read and then reads the pending word on the next two cycles; the bit must stay clear. It also holds a request high through a completion write and reads the pending word twice. The first read must still show the bit clear and the second must show it set, with `irq_o` following. Both cases are judged against a cycle-accurate model of the requirements and against explicitly computed word values.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

   localparam int unsigned BUS_W = 32;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_PRIO,
      ACC_PEND,
      ACC_EN,
      ACC_THR,
      ACC_CLAIM
   } acc_kind_e;

   function automatic int unsigned words_for(input int unsigned n);
      return (n + 31) / 32;
   endfunction

endpackage

// File: rtl/lvl_irq_gate.sv
module lvl_irq_gate #(
   parameter int unsigned NSRC = 40,
   parameter int unsigned IDW  = 6
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] src_i,
   input  logic            claim_fire_i,
   input  logic [IDW-1:0]  claim_id_i,
   input  logic            done_fire_i,
   input  logic [IDW-1:0]  done_id_i,
   output logic [NSRC-1:0] pend_o,
   output logic [NSRC-1:0] clm_o
);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      if (s == 0) begin : g_null
         logic unused_src0;
         assign unused_src0 = src_i[0];
         assign pend_o[0]   = 1'b0;
         assign clm_o[0]    = 1'b0;
      end else begin : g_live
         logic pend_q;
         logic clm_q;
         logic take;
         logic release_hit;

         assign take        = claim_fire_i && (claim_id_i == IDW'(s));
         assign release_hit = done_fire_i  && (done_id_i  == IDW'(s));

         // new requests see the in-service flag as it stood before this edge;
         // a claim clear overrides a same-cycle request
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pend_q <= 1'b0;
               clm_q  <= 1'b0;
            end else begin
               pend_q <= (pend_q | (src_i[s] & ~clm_q)) & ~take;
               clm_q  <= (clm_q | take) & ~release_hit;
            end
         end

         assign pend_o[s] = pend_q;
         assign clm_o[s]  = clm_q;
      end
   end

endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb #(
   parameter int unsigned NSRC        = 40,
   parameter int unsigned PW          = 3,
   parameter int unsigned IDW         = 6,
   parameter bit          PICK_LOW_ID = 1'b1
) (
   input  logic [NSRC-1:0]         pend_i,
   input  logic [NSRC-1:0]         en_i,
   input  logic [NSRC-1:0][PW-1:0] prio_i,
   input  logic [PW-1:0]           thr_i,
   output logic [IDW-1:0]          win_id_o,
   output logic                    win_ok_o
);

   logic [NSRC-1:0] cand;
   assign cand = pend_i & en_i;

   if (PICK_LOW_ID) begin : g_low_first
      // strict compare during an ascending scan keeps the earliest equal
      always_comb begin
         logic [PW-1:0] best_p;
         best_p   = thr_i;
         win_id_o = '0;
         win_ok_o = 1'b0;
         for (int s = 1; s < NSRC; s++) begin
            if (cand[s] && (prio_i[s] > best_p)) begin
               best_p   = prio_i[s];
               win_id_o = IDW'(s);
               win_ok_o = 1'b1;
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         logic [PW-1:0] best_p;
         best_p   = thr_i;
         win_id_o = '0;
         win_ok_o = 1'b0;
         for (int s = 1; s < NSRC; s++) begin
            if (cand[s] && (prio_i[s] > thr_i) &&
                (!win_ok_o || (prio_i[s] >= best_p))) begin
               best_p   = prio_i[s];
               win_id_o = IDW'(s);
               win_ok_o = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
   import lvl_irq_pkg::*;
#(
   parameter int unsigned NSRC       = 40,
   parameter int unsigned PW         = 3,
   parameter int unsigned AW         = 7,
   parameter int unsigned IDW        = 6,
   parameter int unsigned PRIO_BASE  = 0,
   parameter int unsigned PEND_BASE  = 64,
   parameter int unsigned EN_BASE    = 80,
   parameter int unsigned THR_ADDR   = 96,
   parameter int unsigned CLAIM_ADDR = 97
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    bus_rd_i,
   input  logic                    bus_wr_i,
   input  logic [AW-1:0]           bus_addr_i,
   input  logic [BUS_W-1:0]        bus_wdata_i,
   output logic [BUS_W-1:0]        bus_rdata_o,
   input  logic [NSRC-1:0]         pend_i,
   input  logic [IDW-1:0]          win_id_i,
   input  logic                    win_ok_i,
   output logic [NSRC-1:0][PW-1:0] prio_o,
   output logic [NSRC-1:0]         en_o,
   output logic [PW-1:0]           thr_o,
   output logic                    claim_fire_o,
   output logic [IDW-1:0]          claim_id_o,
   output logic                    done_fire_o,
   output logic [IDW-1:0]          done_id_o,
   output logic [IDW-1:0]          active_o
);

   localparam int unsigned NWORD = words_for(NSRC);
   localparam int unsigned PADW  = NWORD * 32;

   acc_kind_e         kind;
   logic [AW-1:0]     prio_off;
   logic [AW-1:0]     pend_off;
   logic [AW-1:0]     en_off;
   logic [PADW-1:0]   pend_pad;
   logic [PADW-1:0]   en_pad;
   logic [BUS_W-1:0]  rd_val;
   logic [BUS_W-1:0]  rdata_q;
   logic [PW-1:0]     thr_q;
   logic [IDW-1:0]    active_q;

   assign prio_off = bus_addr_i - AW'(PRIO_BASE);
   assign pend_off = bus_addr_i - AW'(PEND_BASE);
   assign en_off   = bus_addr_i - AW'(EN_BASE);

   always_comb begin
      kind = ACC_NONE;
      if (bus_addr_i == AW'(CLAIM_ADDR))      kind = ACC_CLAIM;
      else if (bus_addr_i == AW'(THR_ADDR))   kind = ACC_THR;
      else if (pend_off < AW'(NWORD))         kind = ACC_PEND;
      else if (en_off < AW'(NWORD))           kind = ACC_EN;
      else if (prio_off < AW'(NSRC - 1))      kind = ACC_PRIO;
   end

   // per-source configuration storage
   for (genvar s = 0; s < NSRC; s++) begin : g_cfg
      if (s == 0) begin : g_null
         assign prio_o[0] = '0;
         assign en_o[0]   = 1'b0;
      end else begin : g_live
         logic [PW-1:0] p_q;
         logic          e_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               p_q <= '0;
               e_q <= 1'b0;
            end else if (bus_wr_i) begin
               if (kind == ACC_PRIO && prio_off == AW'(s - 1))
                  p_q <= bus_wdata_i[PW-1:0];
               if (kind == ACC_EN && en_off == AW'(s / 32))
                  e_q <= bus_wdata_i[s % 32];
            end
         end
         assign prio_o[s] = p_q;
         assign en_o[s]   = e_q;
      end
   end

   assign pend_pad = PADW'(pend_i);
   assign en_pad   = PADW'(en_o);

   always_comb begin
      rd_val = '0;
      case (kind)
         ACC_PRIO: begin
            for (int s = 1; s < NSRC; s++)
               if (prio_off == AW'(s - 1)) rd_val = BUS_W'(prio_o[s]);
         end
         ACC_PEND: begin
            for (int w = 0; w < NWORD; w++)
               if (pend_off == AW'(w)) rd_val = pend_pad[w*32 +: 32];
         end
         ACC_EN: begin
            for (int w = 0; w < NWORD; w++)
               if (en_off == AW'(w)) rd_val = en_pad[w*32 +: 32];
         end
         ACC_THR:   rd_val = BUS_W'(thr_q);
         ACC_CLAIM: rd_val = win_ok_i ? BUS_W'(win_id_i) : '0;
         default:   rd_val = '0;
      endcase
   end

   assign claim_fire_o = bus_rd_i && (kind == ACC_CLAIM) && win_ok_i;
   assign claim_id_o   = win_id_i;
   assign done_fire_o  = bus_wr_i && (kind == ACC_CLAIM) &&
                         (bus_wdata_i != '0) && (bus_wdata_i < BUS_W'(NSRC));
   assign done_id_o    = bus_wdata_i[IDW-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thr_q    <= '0;
         rdata_q  <= '0;
         active_q <= '0;
      end else begin
         if (bus_wr_i && kind == ACC_THR) thr_q <= bus_wdata_i[PW-1:0];
         if (bus_rd_i) rdata_q <= rd_val;
         if (claim_fire_o)
            active_q <= win_id_i;
         else if (done_fire_o && done_id_o == active_q)
            active_q <= '0;
      end
   end

   assign thr_o       = thr_q;
   assign bus_rdata_o = rdata_q;
   assign active_o    = active_q;

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lvl_irq_pkg::*;
#(
   parameter int unsigned NSRC        = 40,
   parameter int unsigned PW          = 3,
   parameter int unsigned AW          = 7,
   parameter int unsigned PRIO_BASE   = 0,
   parameter int unsigned PEND_BASE   = 64,
   parameter int unsigned EN_BASE     = 80,
   parameter int unsigned THR_ADDR    = 96,
   parameter int unsigned CLAIM_ADDR  = 97,
   parameter bit          PICK_LOW_ID = 1'b1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NSRC-1:0]          src_i,
   input  logic                     bus_rd_i,
   input  logic                     bus_wr_i,
   input  logic [AW-1:0]            bus_addr_i,
   input  logic [31:0]              bus_wdata_i,
   output logic [31:0]              bus_rdata_o,
   output logic                     irq_o,
   output logic [$clog2(NSRC)-1:0]  active_id_o
);

   localparam int unsigned IDW   = $clog2(NSRC);
   localparam int unsigned NWORD = words_for(NSRC);

   if (NSRC < 2 || NSRC > 1024) begin : g_bad_nsrc
      $error("lvl_irq_ctrl: NSRC out of range");
   end
   if (PW < 1 || PW > 8) begin : g_bad_pw
      $error("lvl_irq_ctrl: PW out of range");
   end
   if (PRIO_BASE + NSRC - 1 > PEND_BASE || PEND_BASE + NWORD > EN_BASE ||
       EN_BASE + NWORD > THR_ADDR || THR_ADDR == CLAIM_ADDR ||
       CLAIM_ADDR >= (1 << AW) || THR_ADDR >= (1 << AW)) begin : g_bad_map
      $error("lvl_irq_ctrl: address map overlaps or exceeds AW");
   end

   logic [NSRC-1:0]         pend;
   logic [NSRC-1:0]         clm;
   logic [NSRC-1:0]         en;
   logic [NSRC-1:0][PW-1:0] prio;
   logic [PW-1:0]           thr;
   logic [IDW-1:0]          win_id;
   logic                    win_ok;
   logic                    claim_fire;
   logic [IDW-1:0]          claim_id;
   logic                    done_fire;
   logic [IDW-1:0]          done_id;

   lvl_irq_gate #(
      .NSRC (NSRC),
      .IDW  (IDW)
   ) gate_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .src_i        (src_i),
      .claim_fire_i (claim_fire),
      .claim_id_i   (claim_id),
      .done_fire_i  (done_fire),
      .done_id_i    (done_id),
      .pend_o       (pend),
      .clm_o        (clm)
   );

   lvl_irq_arb #(
      .NSRC        (NSRC),
      .PW          (PW),
      .IDW         (IDW),
      .PICK_LOW_ID (PICK_LOW_ID)
   ) arb_i (
      .pend_i   (pend),
      .en_i     (en),
      .prio_i   (prio),
      .thr_i    (thr),
      .win_id_o (win_id),
      .win_ok_o (win_ok)
   );

   lvl_irq_regs #(
      .NSRC       (NSRC),
      .PW         (PW),
      .AW         (AW),
      .IDW        (IDW),
      .PRIO_BASE  (PRIO_BASE),
      .PEND_BASE  (PEND_BASE),
      .EN_BASE    (EN_BASE),
      .THR_ADDR   (THR_ADDR),
      .CLAIM_ADDR (CLAIM_ADDR)
   ) regs_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .bus_rd_i     (bus_rd_i),
      .bus_wr_i     (bus_wr_i),
      .bus_addr_i   (bus_addr_i),
      .bus_wdata_i  (bus_wdata_i),
      .bus_rdata_o  (bus_rdata_o),
      .pend_i       (pend),
      .win_id_i     (win_id),
      .win_ok_i     (win_ok),
      .prio_o       (prio),
      .en_o         (en),
      .thr_o        (thr),
      .claim_fire_o (claim_fire),
      .claim_id_o   (claim_id),
      .done_fire_o  (done_fire),
      .done_id_o    (done_id),
      .active_o     (active_id_o)
   );

   assign irq_o = win_ok;

endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
   parameter int unsigned NSRC       = 40,
   parameter int unsigned PW         = 3,
   parameter int unsigned AW         = 7,
   parameter int unsigned CLAIM_ADDR = 97
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    bus_rd_i,
   input logic                    bus_wr_i,
   input logic [AW-1:0]           bus_addr_i,
   input logic [31:0]             bus_wdata_i,
   input logic [31:0]             bus_rdata_o,
   input logic                    irq_o,
   input logic [$clog2(NSRC)-1:0] active_id_o,
   input logic [NSRC-1:0]         pend,
   input logic [NSRC-1:0]         clm,
   input logic [PW-1:0]           thr
);

   logic claim_rd;
   logic done_wr;
   assign claim_rd = bus_rd_i && !bus_wr_i && (bus_addr_i == AW'(CLAIM_ADDR));
   assign done_wr  = bus_wr_i && !bus_rd_i && (bus_addr_i == AW'(CLAIM_ADDR));

   // R5: a source in service never carries a pending flag
   a_r5_pend_claim_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend & clm) == '0);

   // R8: a successful claim returns the ID that becomes active
   a_r8_claim_sets_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_rd && irq_o) |=> (bus_rdata_o != '0) && (32'(active_id_o) == bus_rdata_o));

   // R8: an empty claim returns 0 and leaves the active ID alone
   a_r8_empty_claim_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_rd && !irq_o) |=> (bus_rdata_o == '0) && $stable(active_id_o));

   // R9: completing the active ID clears it
   a_r9_done_clears_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_wr && active_id_o != '0 && bus_wdata_i == 32'(active_id_o)) |=> (active_id_o == '0));

   // R6: a threshold at the top value silences the line
   a_r6_thr_top_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr == '1) |-> !irq_o);

   // R6: with nothing pending the line is low
   a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend == '0) |-> !irq_o);

endmodule

bind lvl_irq_ctrl lvl_irq_chk #(
   .NSRC       (NSRC),
   .PW         (PW),
   .AW         (AW),
   .CLAIM_ADDR (CLAIM_ADDR)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_rd_i    (bus_rd_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .active_id_o (active_id_o),
   .pend        (pend),
   .clm         (clm),
   .thr         (thr)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;

   localparam int NS    = 40;
   localparam int PW    = 3;
   localparam int AW    = 7;
   localparam int IDW   = $clog2(NS);
   localparam int A_PEND  = 64;
   localparam int A_EN    = 80;
   localparam int A_THR   = 96;
   localparam int A_CLAIM = 97;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS-1:0]   src = '0;
   logic            rd = 1'b0;
   logic            wr = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic            irq;
   logic [IDW-1:0]  act_id;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   lvl_irq_ctrl #(
      .NSRC (NS), .PW (PW), .AW (AW),
      .PRIO_BASE (0), .PEND_BASE (A_PEND), .EN_BASE (A_EN),
      .THR_ADDR (A_THR), .CLAIM_ADDR (A_CLAIM), .PICK_LOW_ID (1'b1)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .src_i (src),
      .bus_rd_i (rd), .bus_wr_i (wr), .bus_addr_i (addr),
      .bus_wdata_i (wdata), .bus_rdata_o (rdata),
      .irq_o (irq), .active_id_o (act_id)
   );

   // ---------------- requirement model ----------------
   logic [NS-1:0] m_pend, m_clm, m_en;
   int            m_prio [NS];
   int            m_thr, m_act;
   logic [31:0]   m_rdata;

   function automatic int m_win();
      int best = 0;
      int bp = m_thr;
      for (int s = 1; s < NS; s++)
         if (m_pend[s] && m_en[s] && m_prio[s] > bp) begin
            best = s;
            bp = m_prio[s];
         end
      return best;
   endfunction

   function automatic logic [31:0] m_read(input int a, input int w);
      if (a < NS - 1)        return 32'(m_prio[a + 1]);
      if (a == A_PEND)       return m_pend[31:0];
      if (a == A_PEND + 1)   return 32'(m_pend[NS-1:32]);
      if (a == A_EN)         return m_en[31:0];
      if (a == A_EN + 1)     return 32'(m_en[NS-1:32]);
      if (a == A_THR)        return 32'(m_thr);
      if (a == A_CLAIM)      return 32'(w);
      return 32'h0;
   endfunction

   always @(posedge clk) begin : model
      int w;
      logic [NS-1:0] np;
      if (!rst_n) begin
         m_pend = '0; m_clm = '0; m_en = '0;
         for (int s = 0; s < NS; s++) m_prio[s] = 0;
         m_thr = 0; m_act = 0; m_rdata = '0;
      end else begin
         w  = m_win();
         np = m_pend | (src & ~m_clm);
         np[0] = 1'b0;
         if (rd) begin
            m_rdata = m_read(int'(addr), w);
            if (int'(addr) == A_CLAIM && w != 0) begin
               np[w] = 1'b0;
               m_clm[w] = 1'b1;
               m_act = w;
            end
         end
         m_pend = np;
         if (wr) begin
            if (int'(addr) < NS - 1) m_prio[int'(addr) + 1] = int'(wdata[2:0]);
            else if (int'(addr) == A_EN) begin
               m_en[31:1] = wdata[31:1];
            end else if (int'(addr) == A_EN + 1) begin
               m_en[NS-1:32] = wdata[NS-33:0];
            end else if (int'(addr) == A_THR) m_thr = int'(wdata[2:0]);
            else if (int'(addr) == A_CLAIM && wdata != 0 && wdata < NS) begin
               m_clm[wdata] = 1'b0;
               if (int'(wdata) == m_act) m_act = 0;
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic chk_state(input string tag);
      chk({tag, " irq_o"}, 32'(irq), 32'(m_win() != 0));
      chk({tag, " active_id_o"}, 32'(act_id), 32'(m_act));
   endtask

   task automatic wr_op(input int a, input logic [31:0] d);
      addr = AW'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_op(input int a, output logic [31:0] q);
      addr = AW'(a); rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      q = rdata;
      chk($sformatf("model read @%0d", a), q, m_rdata);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin : stim
      logic [31:0] q;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq_o after reset", 32'(irq), 32'h0);
      chk("R1 active_id_o after reset", 32'(act_id), 32'h0);
      rd_op(A_THR, q);   chk("R1 threshold", q, 32'h0);
      rd_op(A_PEND, q);  chk("R1 pending word", q, 32'h0);
      rd_op(A_EN, q);    chk("R1 enable word", q, 32'h0);
      rd_op(A_CLAIM, q); chk("R1 empty claim", q, 32'h0);

      // R2 priority sweep with junk in the upper data bits
      for (int s = 1; s < NS; s++)
         wr_op(s - 1, 32'hA5A5_0000 | 32'(s << 3) | 32'(s % 8));
      for (int s = 1; s < NS; s++) begin
         rd_op(s - 1, q);
         chk($sformatf("R2 priority of source %0d", s), q, 32'(s % 8));
      end
      wr_op(NS - 1, 32'h7);
      rd_op(NS - 1, q); chk("R2 reserved word", q, 32'h0);

      // R3 enable packing
      wr_op(A_THR, 32'h7);
      wr_op(A_EN, 32'hFFFF_FFFF);
      rd_op(A_EN, q);     chk("R3 enable word 0, source 0 stuck low", q, 32'hFFFF_FFFE);
      wr_op(A_EN + 1, 32'hFFFF_FFFF);
      rd_op(A_EN + 1, q); chk("R3 enable word 1, unused bits low", q, 32'h0000_00FF);

      // R4 latch a one-cycle pulse on every source
      src = '1;
      @(negedge clk);
      src = '0;
      @(negedge clk);
      rd_op(A_PEND, q);     chk("R4 pending word 0", q, 32'hFFFF_FFFE);
      rd_op(A_PEND + 1, q); chk("R4 pending word 1", q, 32'h0000_00FF);
      wr_op(A_PEND, 32'h0);
      rd_op(A_PEND, q);     chk("R4 pending ignores writes", q, 32'hFFFF_FFFE);
      chk("R6 threshold 7 keeps line low", 32'(irq), 32'h0);

      // R6/R10 threshold sweep
      for (int t = 7; t >= 0; t--) begin
         wr_op(A_THR, 32'(t));
         chk($sformatf("R10 irq_o after threshold %0d", t), 32'(irq), 32'(t < 7));
         chk_state("R6 sweep");
      end

      // R7/R8 full claim order: priority s%8, ties to lowest ID
      for (int p = 7; p >= 1; p--)
         for (int s = p; s < NS; s += 8) begin
            rd_op(A_CLAIM, q);
            chk($sformatf("R7 claim order prio %0d", p), q, 32'(s));
            chk("R8 active after claim", 32'(act_id), 32'(s));
         end
      rd_op(A_CLAIM, q);
      chk("R8 empty claim returns 0", q, 32'h0);
      chk("R8 empty claim keeps active", 32'(act_id), 32'd33);
      chk_state("R8 after drain");

      // R5 in-service sources ignore requests
      src = '1;
      repeat (2) @(negedge clk);
      src = '0;
      @(negedge clk);
      rd_op(A_PEND, q);     chk("R5 word 0 only free sources", q, 32'h0101_0100);
      rd_op(A_PEND + 1, q); chk("R5 word 1 only free sources", q, 32'h0000_0001);

      // R9 completion rules
      wr_op(A_CLAIM, 32'h0);
      chk("R9 completion of 0 ignored", 32'(act_id), 32'd33);
      wr_op(A_CLAIM, 32'd45);
      chk("R9 out-of-range completion ignored", 32'(act_id), 32'd33);
      wr_op(A_CLAIM, 32'd7);
      chk("R9 non-active completion keeps active", 32'(act_id), 32'd33);
      src[7] = 1'b1;
      @(negedge clk);
      src[7] = 1'b0;
      @(negedge clk);
      rd_op(A_PEND, q);     chk("R9 released source latches again", q, 32'h0101_0180);
      chk("R10 irq_o after release", 32'(irq), 32'h1);
      wr_op(A_CLAIM, 32'd33);
      chk("R9 active completion clears", 32'(act_id), 32'h0);
      rd_op(A_CLAIM, q);    chk("R8 reclaim source 7", q, 32'd7);
      wr_op(A_CLAIM, 32'd7);
      chk("R9 active cleared again", 32'(act_id), 32'h0);
      chk_state("R9 end");

      // R12 completion while the level is still high
      src[5] = 1'b1;
      wr_op(A_CLAIM, 32'd5);
      rd_op(A_PEND, q);     chk("R12 first cycle still clear", q, 32'h0101_0100);
      rd_op(A_PEND, q);     chk("R12 pending set one cycle later", q, 32'h0101_0120);
      chk("R12 irq_o raised", 32'(irq), 32'h1);

      // R11 claim and request in the same cycle
      rd_op(A_CLAIM, q);    chk("R11 claim returns 5", q, 32'd5);
      rd_op(A_PEND, q);     chk("R11 clear wins over request", q, 32'h0101_0100);
      rd_op(A_PEND, q);     chk("R11 stays blocked", q, 32'h0101_0100);
      chk("R11 irq_o low", 32'(irq), 32'h0);
      src[5] = 1'b0;

      // R10/R6 recompute after config writes
      wr_op(7, 32'd4);
      chk("R10 priority write raises line", 32'(irq), 32'h1);
      rd_op(A_CLAIM, q);    chk("R10 claim source 8", q, 32'd8);
      chk("R10 line drops after claim", 32'(irq), 32'h0);
      wr_op(15, 32'd3);
      chk("R10 priority of 16 raises line", 32'(irq), 32'h1);
      wr_op(A_EN, 32'hFFFE_FFFF);
      chk("R6 disabled source not eligible", 32'(irq), 32'h0);
      wr_op(A_EN, 32'hFFFF_FFFF);
      chk("R6 re-enabled source eligible", 32'(irq), 32'h1);
      wr_op(A_THR, 32'd3);
      chk("R6 equal to threshold not eligible", 32'(irq), 32'h0);
      wr_op(A_THR, 32'd2);
      chk("R6 above threshold eligible", 32'(irq), 32'h1);
      rd_op(A_CLAIM, q);    chk("R8 claim source 16", q, 32'd16);
      chk_state("final");

      finish_run();
   end

endmodule